// File: doc/BRIEF.md
# Key-Locked Reset and Flag Register Slice

This block is a small memory-mapped register slice on a plain 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. The slice holds four kinds of state:

- a 16-bit lock word;
- a reset-level register, guarded by the lock;
- a volatile flag word, with separate set and clear addresses;
- a non-volatile flag word, also with separate set and clear addresses.

Software arms the lock by writing a magic key, then writes the reset-level register. A write that sets the trigger bit produces a one-clock system reset request. The position of that trigger bit depends on a board-variant parameter.

Two reset inputs exist. The soft reset `rst_ni` clears the lock, the volatile flags and the reset level. The non-volatile flags survive it and clear only on the power-on reset `por_ni`. The block does not sequence the system reset itself. It only emits the request.

Top module: `keylock_sysreg`

## Requirements
- R1: The lock word is at offset 0x20 and reads back zero-extended to 32 bits. A write of exactly 0x0000A05F stores 0xA05F. Any other write stores the low 16 bits with bit 15 forced to 0.
- R2: A write to offset 0x40 updates the reset level only while the lock word equals 0xA05F. Otherwise the write has no effect on the level or on `rst_req_o`.
- R3: With VARIANT 0, a locked write to 0x40 with bit 8 set raises `rst_req_o`. Bit 2 alone does not.
- R4: With VARIANT 1 or 2, a locked write to 0x40 with bit 2 set raises `rst_req_o`. Bit 8 alone does not.
- R5: With any VARIANT of 3 or more, offset 0x40 reads zero, writes to it are ignored, and `rst_req_o` never rises.
- R6: A write to 0x30 ORs the write data into the volatile flags. A write to 0x34 clears every flag bit that is set in the write data. Offset 0x30 reads the flags.
- R7: The non-volatile flags behave the same way: set at 0x38, clear at 0x3C, read at 0x38.
- R8: Asserting `rst_ni` clears the lock word, the volatile flags and the reset level. It leaves the non-volatile flags unchanged.
- R9: Asserting `por_ni` clears the non-volatile flags.
- R10: `rst_req_o` is high for exactly the one clock after the edge that captures a qualifying write.
- R11: Every other address, including the clear addresses 0x34 and 0x3C, reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async soft reset |
| por_ni | input | 1 | Active-low async power-on reset for the non-volatile flags |
| addr_i | input | 8 | Byte offset of the access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| rst_req_o | output | 1 | One-clock system reset request |

## Verification
The bench builds three copies of the block on one shared bus, with VARIANT 0, 1 and 3. Each write therefore shows the bit-8 trigger, the bit-2 trigger and the read-as-zero behaviour side by side. The flag words are swept with a sequence of computed patterns against an arithmetic model. Lock-key edge values are written, including the key with extra upper bits set. Both resets are exercised to show which state each one clears.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  localparam int unsigned LOCK_KEY  = 32'h0000_A05F;
  localparam int unsigned OFF_LOCK  = 'h20;
  localparam int unsigned OFF_FSET  = 'h30;
  localparam int unsigned OFF_FCLR  = 'h34;
  localparam int unsigned OFF_NVSET = 'h38;
  localparam int unsigned OFF_NVCLR = 'h3C;
  localparam int unsigned OFF_RCTL  = 'h40;

  // trigger bit per board variant; -1 means no reset control
  function automatic int trig_bit(input int variant);
    if (variant == 0) return 8;
    if (variant == 1 || variant == 2) return 2;
    return -1;
  endfunction
endpackage

// File: rtl/keylock_lock_reg.sv
module keylock_lock_reg
  import keylock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [15:0]       lock_o,
  output logic              unlocked_o
);
  logic [15:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= '0;
    else if (wr_i) begin
      if (wdata_i == DATA_W'(LOCK_KEY)) lock_q <= 16'(LOCK_KEY);
      else lock_q <= {1'b0, wdata_i[14:0]};
    end
  end

  assign lock_o     = lock_q;
  assign unlocked_o = (lock_q == 16'(LOCK_KEY));

  AST_LOCK_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q[15] |-> unlocked_o) else $error("lock bit15 without key"); // R1
endmodule

// File: rtl/keylock_flag_reg.sv
module keylock_flag_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) q <= '0;
    else if (set_i) q <= q | wdata_i;
    else if (clr_i) q <= q & ~wdata_i;
  end

  assign q_o = q;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!arst_ni)
    set_i |=> ((q & $past(wdata_i)) == $past(wdata_i))) else $error("set lost"); // R6
  AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (clr_i && !set_i) |=> ((q & $past(wdata_i)) == '0)) else $error("clear lost"); // R7
endmodule

// File: rtl/keylock_rstctl.sv
module keylock_rstctl
  import keylock_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int VARIANT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              unlocked_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] level_o,
  output logic              req_o
);
  localparam int TRIG = trig_bit(VARIANT);

  generate
    if (TRIG >= 0) begin : g_ctl
      logic [DATA_W-1:0] level_q;
      logic              req_q;
      logic              take;
      assign take = wr_i && unlocked_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          level_q <= '0;
          req_q   <= 1'b0;
        end else begin
          req_q <= take && wdata_i[TRIG];
          if (take) level_q <= wdata_i;
        end
      end

      assign level_o = level_q;
      assign req_o   = req_q;

      AST_LEVEL_KEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(level_q) |-> $past(wr_i && unlocked_i)) else $error("unkeyed level change"); // R2
      AST_REQ_KEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_q |-> $past(wr_i && unlocked_i)) else $error("unkeyed request"); // R2
    end else begin : g_none
      logic unused_in;
      assign unused_in = ^{wr_i, unlocked_i, wdata_i, clk_i, rst_ni};
      assign level_o   = '0;
      assign req_o     = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/keylock_sysreg.sv
module keylock_sysreg
  import keylock_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int VARIANT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  logic [15:0]       lock_w;
  logic              unlocked_w;
  logic [DATA_W-1:0] flags_w, nvflags_w, level_w;

  logic wr_lock, wr_fset, wr_fclr, wr_nvset, wr_nvclr, wr_rctl;
  assign wr_lock  = we_i && (addr_i == ADDR_W'(OFF_LOCK));
  assign wr_fset  = we_i && (addr_i == ADDR_W'(OFF_FSET));
  assign wr_fclr  = we_i && (addr_i == ADDR_W'(OFF_FCLR));
  assign wr_nvset = we_i && (addr_i == ADDR_W'(OFF_NVSET));
  assign wr_nvclr = we_i && (addr_i == ADDR_W'(OFF_NVCLR));
  assign wr_rctl  = we_i && (addr_i == ADDR_W'(OFF_RCTL));

  keylock_lock_reg #(.DATA_W(DATA_W)) u_lock (
    .clk_i, .rst_ni, .wr_i(wr_lock), .wdata_i,
    .lock_o(lock_w), .unlocked_o(unlocked_w)
  );

  keylock_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk_i, .arst_ni(rst_ni), .set_i(wr_fset), .clr_i(wr_fclr),
    .wdata_i, .q_o(flags_w)
  );

  keylock_flag_reg #(.DATA_W(DATA_W)) u_nvflags (
    .clk_i, .arst_ni(por_ni), .set_i(wr_nvset), .clr_i(wr_nvclr),
    .wdata_i, .q_o(nvflags_w)
  );

  keylock_rstctl #(.DATA_W(DATA_W), .VARIANT(VARIANT)) u_rstctl (
    .clk_i, .rst_ni, .wr_i(wr_rctl), .unlocked_i(unlocked_w),
    .wdata_i, .level_o(level_w), .req_o(rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFF_LOCK):  rdata_o = DATA_W'(lock_w);
      ADDR_W'(OFF_FSET):  rdata_o = flags_w;
      ADDR_W'(OFF_NVSET): rdata_o = nvflags_w;
      ADDR_W'(OFF_RCTL):  rdata_o = level_w;
      default:            rdata_o = '0;
    endcase
  end

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o) else $error("request wider than one clock"); // R10
  AST_REQ_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(wr_rctl)) else $error("request without write"); // R10
endmodule

// File: tb/keylock_sysreg_tb_top.sv
module keylock_sysreg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic [7:0] addr = '0;
  logic we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd0, rd1, rd3;
  logic req0, req1, req3;
  int n_tests = 0, n_fail = 0;
  bit p0, p1, p3, q0, q1, q3;

  always #5 clk = ~clk;

  keylock_sysreg #(.VARIANT(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rd0), .rst_req_o(req0));
  keylock_sysreg #(.VARIANT(1)) dut_v1_i (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rd1), .rst_req_o(req1));
  keylock_sysreg #(.VARIANT(3)) dut_v3_i (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rd3), .rst_req_o(req3));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // p* = request right after capture edge, q* = one clock later
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(posedge clk); #1; p0 = req0; p1 = req1; p3 = req3;
    @(negedge clk); we = 1'b0;
    @(posedge clk); #1; q0 = req0; q1 = req1; q3 = req3;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk); addr = a; #1;
  endtask

  initial begin
    logic [31:0] fexp, nexp, pat;
    #1_000_000;
    n_fail++; n_tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] fexp, nexp, pat;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; por_n = 1'b1;

    // reset state (R8, R9)
    rd(8'h20); chk("R8 lock", rd0, 0);
    rd(8'h30); chk("R8 flags", rd0, 0);
    rd(8'h38); chk("R9 nv", rd0, 0);
    rd(8'h40); chk("R8 level", rd0, 0);
    chk("R10 idle", {29'b0, req0, req1, req3}, 0);

    // R1 lock forms
    wr(8'h20, 32'h1234); rd(8'h20); chk("R1 plain", rd0, 32'h1234);
    wr(8'h20, 32'hFFFF); rd(8'h20); chk("R1 bit15", rd0, 32'h7FFF);
    wr(8'h20, 32'h1A05F); rd(8'h20); chk("R1 upper", rd0, 32'h205F);
    // R2 unlocked write ignored
    wr(8'h40, 32'h104);
    chk("R2 no req", {29'b0, p0, p1, p3}, 0);
    rd(8'h40); chk("R2 v0 level", rd0, 0); chk("R2 v1 level", rd1, 0);
    wr(8'h20, 32'hA05F); rd(8'h20); chk("R1 key", rd0, 32'hA05F);

    // bit 2 write: R3 v0 silent, R4 v1 fires, R5 v3 silent
    wr(8'h40, 32'h004);
    chk("R3 v0 bit2", {31'b0, p0}, 0);
    chk("R4 v1 bit2", {31'b0, p1}, 1);
    chk("R5 v3 bit2", {31'b0, p3}, 0);
    chk("R10 v1 drop", {31'b0, q1}, 0);
    rd(8'h40); chk("R2 v0 level", rd0, 32'h4); chk("R4 v1 level", rd1, 32'h4);
    chk("R5 v3 read", rd3, 0);
    // bit 8 write
    wr(8'h40, 32'h100);
    chk("R3 v0 bit8", {31'b0, p0}, 1);
    chk("R10 v0 drop", {31'b0, q0}, 0);
    chk("R4 v1 bit8", {31'b0, p1}, 0);
    chk("R5 v3 bit8", {31'b0, p3}, 0);
    rd(8'h40); chk("R3 v0 level", rd0, 32'h100); chk("R5 v3 read", rd3, 0);
    // relock off then write ignored
    wr(8'h20, 32'h0); wr(8'h40, 32'h1FF);
    chk("R2 relock req", {29'b0, p0, p1, p3}, 0);
    rd(8'h40); chk("R2 relock level", rd0, 32'h100);

    // R6/R7 sweeps
    fexp = 0; nexp = 0; pat = 32'h1;
    for (int i = 0; i < 24; i++) begin
      pat = pat * 32'd1103515245 + 32'd12345;
      if (i % 3 == 2) begin
        wr(8'h34, pat); fexp &= ~pat;
        wr(8'h3C, ~pat); nexp &= pat;
      end else begin
        wr(8'h30, pat & 32'h0F0F_F0F0 ^ (32'h1 << i)); fexp |= pat & 32'h0F0F_F0F0 ^ (32'h1 << i);
        wr(8'h38, pat >> (i % 7)); nexp |= pat >> (i % 7);
      end
      rd(8'h30); chk("R6 flags", rd1, fexp);
      rd(8'h38); chk("R7 nvflags", rd3, nexp);
    end
    wr(8'h30, 32'hFFFF_FFFF); wr(8'h38, 32'hA5A5_5A5A);
    nexp |= 32'hA5A5_5A5A;
    rd(8'h34); chk("R11 fclr", rd0, 0);
    rd(8'h3C); chk("R11 nvclr", rd0, 0);
    rd(8'h44); chk("R11 unmapped", rd0, 0);
    rd(8'hFC); chk("R11 top", rd0, 0);

    // R8 soft reset
    wr(8'h20, 32'hA05F);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    rd(8'h20); chk("R8 lock", rd0, 0);
    rd(8'h30); chk("R8 flags", rd0, 0);
    rd(8'h40); chk("R8 level", rd0, 0);
    rd(8'h38); chk("R8 nv kept", rd0, nexp);
    // R9 power-on reset
    @(negedge clk); por_n = 1'b0; @(negedge clk); por_n = 1'b1;
    rd(8'h38); chk("R9 nv", rd0, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule